// File: doc/BRIEF.md
# Bidirectional Accumulator Shifter

This block shifts one of two 40-bit accumulators left or right, either logically or arithmetically, and returns the result with its status flags. It decodes the 16-bit instruction word itself. The shift distance comes from one of three places. It can be a 6-bit count inside the instruction. It can be a signed 16-bit word taken from the middle of an accumulator or from the high half of an auxiliary register, where the sign of that word picks the direction. Or it can be a fixed distance of 16.

Words that are not one of the shift forms, and cycles without `valid_i`, produce no result. Each accepted instruction yields one registered result one clock later. The result carries the destination accumulator index, the 40-bit value, and zero, sign and overflow flags. The caller writes the result back; instruction fetch and other arithmetic sit outside.

Top module: `acc_shift_unit`

## Requirements
- R1: Immediate form: word bits 15:9 = 0001010, bit 8 selects the accumulator (and destination), bits 7:6 give the mode (00 logical left, 01 logical right, 10 arithmetic left, 11 arithmetic right), bits 5:0 hold the count field; left modes shift by the field value.
- R2: Immediate right modes shift by 64 minus the count field, so a field of 0 means a shift of 64.
- R3: An immediate left shift with a count field of 0 returns the accumulator unchanged.
- R4: Logical right shifts fill with zeros from bit 39; arithmetic right shifts fill with copies of bit 39; left shifts of both kinds fill with zeros and drop bits beyond bit 39.
- R5: A shift distance of 40 or more gives all zeros, except for an arithmetic right shift, which gives 40 copies of bit 39.
- R6: Words 0x02CA (logical) and 0x02CB (arithmetic) shift accumulator 0 by the signed word in bits 31:16 of accumulator 1: a positive amount shifts right, a negative amount shifts left by its magnitude, zero leaves the value unchanged; the destination is accumulator 0.
- R7: Words 0011 01sd 1xxx xxxx (logical) and 0011 10sd 1xxx xxxx (arithmetic) shift accumulator d by the signed auxiliary high word s: a positive amount shifts left, a negative amount shifts right.
- R8: Words 0011 11ad 1xxx xxxx shift accumulator d by the signed bits 31:16 of the other accumulator, logical when a=0 and arithmetic when a=1, with a positive amount shifting left and a negative amount shifting right.
- R9: Word 1111 000r xxxx xxxx shifts accumulator r logically left by 16, 1111 010r xxxx xxxx logically right by 16, and 1001 r001 xxxx xxxx arithmetically right by 16 (r at bit 11).
- R10: With each result, zero_o is set when the 40-bit result is 0, sign_o equals result bit 39, and ovf_o is 0.
- R11: A result appears with valid_o one clock after a cycle with valid_i high and a shift word; any other word, or valid_i low, gives valid_o low in the next cycle.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present |
| instr_i | input | 16 | Instruction word |
| acc0_i | input | 40 | Accumulator 0 |
| acc1_i | input | 40 | Accumulator 1 |
| axh0_i | input | 16 | Auxiliary high word 0 |
| axh1_i | input | 16 | Auxiliary high word 1 |
| valid_o | output | 1 | Result present |
| dst_o | output | 1 | Destination accumulator index |
| res_o | output | 40 | Shifted accumulator |
| zero_o | output | 1 | Result is zero |
| sign_o | output | 1 | Result bit 39 |
| ovf_o | output | 1 | Overflow flag, always cleared |

## Verification
The bench drives immediate right fields of 0 and 60. A design that used the raw field, instead of 64 minus the field, would shift by 0 or 60 rather than by 64 or 4. It checks that the two register-driven families turn the same sign into opposite directions, and that a zero amount changes nothing; a swapped polarity would shift the wrong way. It also uses distances of 40 and more, including 100 and 64, on negative values. A barrel shifter that only used the low bits of the distance would wrap around, and a logical right shift that sign-filled would leave ones where zeros belong. Non-shift words and idle cycles must give no result, which catches a decoder that matches too widely.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  localparam int ACC_W          = 40;
  localparam int WORD_W         = 16;
  localparam int CNT_W          = 6;   // immediate count field width
  localparam int IMM_RIGHT_BASE = 64;  // right count = base - field
endpackage

// File: rtl/acc_shift_decode.sv
module acc_shift_decode
  import acc_shift_pkg::*;
#(
  parameter int WORD_W_P = WORD_W,
  localparam int AMT_W   = WORD_W_P + 1
) (
  input  logic [15:0]         instr_i,
  input  logic [WORD_W_P-1:0] mid0_i,
  input  logic [WORD_W_P-1:0] mid1_i,
  input  logic [WORD_W_P-1:0] axh0_i,
  input  logic [WORD_W_P-1:0] axh1_i,
  output logic                hit_o,
  output logic                dst_o,
  output logic                left_o,
  output logic                arith_o,
  output logic [AMT_W-1:0]    amt_o
);
  function automatic logic [AMT_W-1:0] magnitude(input logic [WORD_W_P-1:0] s);
    logic [AMT_W-1:0] ext;
    ext = {s[WORD_W_P-1], s};
    return s[WORD_W_P-1] ? (~ext + 1'b1) : ext;
  endfunction

  logic [WORD_W_P-1:0] reg_amt;

  always_comb begin
    hit_o   = 1'b0;
    dst_o   = 1'b0;
    left_o  = 1'b0;
    arith_o = 1'b0;
    amt_o   = '0;
    reg_amt = '0;
    if (instr_i[15:9] == 7'b0001010) begin
      hit_o   = 1'b1;
      dst_o   = instr_i[8];
      arith_o = instr_i[7];
      left_o  = ~instr_i[6];
      if (instr_i[6])
        amt_o = AMT_W'(IMM_RIGHT_BASE - int'(instr_i[CNT_W-1:0]));
      else
        amt_o = AMT_W'(instr_i[CNT_W-1:0]);
    end else if (instr_i[15:1] == 15'h0165) begin
      // fixed operands: positive amount means right
      hit_o   = 1'b1;
      arith_o = instr_i[0];
      reg_amt = mid1_i;
      left_o  = reg_amt[WORD_W_P-1];
      amt_o   = magnitude(reg_amt);
    end else if (instr_i[15:12] == 4'b0011 && instr_i[7] && instr_i[11:10] != 2'b00) begin
      // register operands: positive amount means left
      hit_o = 1'b1;
      dst_o = instr_i[8];
      if (instr_i[11:10] == 2'b11) begin
        arith_o = instr_i[9];
        reg_amt = instr_i[8] ? mid0_i : mid1_i;
      end else begin
        arith_o = instr_i[11];
        reg_amt = instr_i[9] ? axh1_i : axh0_i;
      end
      left_o = ~reg_amt[WORD_W_P-1];
      amt_o  = magnitude(reg_amt);
    end else if (instr_i[15:12] == 4'b1111 && !instr_i[11] && !instr_i[9]) begin
      hit_o  = 1'b1;
      dst_o  = instr_i[8];
      left_o = ~instr_i[10];
      amt_o  = AMT_W'(WORD_W_P);
    end else if (instr_i[15:12] == 4'b1001 && instr_i[10:8] == 3'b001) begin
      hit_o   = 1'b1;
      dst_o   = instr_i[11];
      arith_o = 1'b1;
      amt_o   = AMT_W'(WORD_W_P);
    end
  end
endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core
  import acc_shift_pkg::*;
#(
  parameter int ACC_W_P = ACC_W,
  parameter int AMT_W   = WORD_W + 1,
  localparam int SH_W   = $clog2(ACC_W_P)
) (
  input  logic [ACC_W_P-1:0] val_i,
  input  logic               left_i,
  input  logic               arith_i,
  input  logic [AMT_W-1:0]   amt_i,
  output logic [ACC_W_P-1:0] res_o
);
  logic [SH_W-1:0] sh;
  assign sh = amt_i[SH_W-1:0];

  always_comb begin
    if (amt_i >= AMT_W'(ACC_W_P))
      res_o = (arith_i && !left_i && val_i[ACC_W_P-1]) ? '1 : '0;
    else if (left_i)
      res_o = val_i << sh;
    else if (arith_i)
      res_o = $signed(val_i) >>> sh;
    else
      res_o = val_i >> sh;
  end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_shift_pkg::*;
#(
  parameter int ACC_W_P  = ACC_W,
  parameter int WORD_W_P = WORD_W,
  localparam int AMT_W   = WORD_W_P + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [15:0]         instr_i,
  input  logic [ACC_W_P-1:0]  acc0_i,
  input  logic [ACC_W_P-1:0]  acc1_i,
  input  logic [WORD_W_P-1:0] axh0_i,
  input  logic [WORD_W_P-1:0] axh1_i,
  output logic                valid_o,
  output logic                dst_o,
  output logic [ACC_W_P-1:0]  res_o,
  output logic                zero_o,
  output logic                sign_o,
  output logic                ovf_o
);
  logic               hit, dst, left, arith;
  logic [AMT_W-1:0]   amt;
  logic [ACC_W_P-1:0] src, shifted;

  acc_shift_decode #(.WORD_W_P(WORD_W_P)) u_dec (
    .instr_i (instr_i),
    .mid0_i  (acc0_i[2*WORD_W_P-1:WORD_W_P]),
    .mid1_i  (acc1_i[2*WORD_W_P-1:WORD_W_P]),
    .axh0_i  (axh0_i),
    .axh1_i  (axh1_i),
    .hit_o   (hit),
    .dst_o   (dst),
    .left_o  (left),
    .arith_o (arith),
    .amt_o   (amt)
  );

  assign src = dst ? acc1_i : acc0_i;

  acc_shift_core #(.ACC_W_P(ACC_W_P), .AMT_W(AMT_W)) u_core (
    .val_i   (src),
    .left_i  (left),
    .arith_i (arith),
    .amt_i   (amt),
    .res_o   (shifted)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dst_o   <= 1'b0;
      res_o   <= '0;
      zero_o  <= 1'b0;
      sign_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i && hit;
      if (valid_i && hit) begin
        dst_o  <= dst;
        res_o  <= shifted;
        zero_o <= (shifted == '0);
        sign_o <= shifted[ACC_W_P-1];
        ovf_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acc_shift_chk.sv
module acc_shift_chk #(
  parameter int ACC_W_P  = 40,
  parameter int WORD_W_P = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [15:0]         instr_i,
  input logic [ACC_W_P-1:0]  acc0_i,
  input logic [ACC_W_P-1:0]  acc1_i,
  input logic                valid_o,
  input logic [ACC_W_P-1:0]  res_o,
  input logic                zero_o,
  input logic                sign_o
);
  a_r11_idle_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r10_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (zero_o == (res_o == '0)));

  a_r10_sign_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sign_o == res_o[ACC_W_P-1]));

  a_r3_left_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:9] == 7'b0001010 && !instr_i[6] && instr_i[5:0] == 6'd0)
    |=> (valid_o && res_o == $past(instr_i[8] ? acc1_i : acc0_i)));

  a_r6_zero_amount: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:1] == 15'h0165 && acc1_i[2*WORD_W_P-1:WORD_W_P] == '0)
    |=> (valid_o && res_o == $past(acc0_i)));

  a_r9_left16_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[15:9] == 7'b1111000) |=> (valid_o && res_o[WORD_W_P-1:0] == '0));
endmodule

bind acc_shift_unit acc_shift_chk #(.ACC_W_P(ACC_W_P), .WORD_W_P(WORD_W_P)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .instr_i (instr_i),
  .acc0_i  (acc0_i),
  .acc1_i  (acc1_i),
  .valid_o (valid_o),
  .res_o   (res_o),
  .zero_o  (zero_o),
  .sign_o  (sign_o)
);

// File: tb/acc_shift_unit_tb_top.sv
module acc_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [39:0] acc0_i = '0, acc1_i = '0;
  logic [15:0] axh0_i = '0, axh1_i = '0;
  logic        valid_o, dst_o, zero_o, sign_o, ovf_o;
  logic [39:0] res_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    bit          v;
    bit          d;
    logic [39:0] r;
    int          due;
    string       tag;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_shift_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .acc0_i(acc0_i), .acc1_i(acc1_i), .axh0_i(axh0_i), .axh1_i(axh1_i),
    .valid_o(valid_o), .dst_o(dst_o), .res_o(res_o),
    .zero_o(zero_o), .sign_o(sign_o), .ovf_o(ovf_o)
  );

  // reference shifts on 40-bit values
  function automatic logic [39:0] m_shl(input logic [39:0] v, input int n);
    logic [79:0] w;
    if (n >= 40) return '0;
    w = {40'd0, v} << n;
    return w[39:0];
  endfunction
  function automatic logic [39:0] m_shr(input logic [39:0] v, input int n);
    if (n >= 40) return '0;
    return v >> n;
  endfunction
  function automatic logic [39:0] m_sar(input logic [39:0] v, input int n);
    logic [79:0] w;
    w = {{40{v[39]}}, v};
    if (n >= 40) return {40{v[39]}};
    w = w >> n;
    return w[39:0];
  endfunction

  function automatic void model(input logic [15:0] op, input logic [39:0] a0, a1,
                                input logic [15:0] x0, x1,
                                output bit hit, output bit d, output logic [39:0] r);
    logic [39:0] v;
    int s;
    hit = 1'b0; d = 1'b0; r = '0;
    if (op[15:9] == 7'b0001010) begin
      hit = 1'b1; d = op[8]; v = d ? a1 : a0;
      case (op[7:6])
        2'b00, 2'b10: r = m_shl(v, int'(op[5:0]));
        2'b01:        r = m_shr(v, 64 - int'(op[5:0]));
        default:      r = m_sar(v, 64 - int'(op[5:0]));
      endcase
    end else if (op == 16'h02CA || op == 16'h02CB) begin
      hit = 1'b1; d = 1'b0; s = int'($signed(a1[31:16]));
      if (s > 0) r = op[0] ? m_sar(a0, s) : m_shr(a0, s);
      else       r = m_shl(a0, -s);
    end else if (op[15:12] == 4'b0011 && op[7] && op[11:10] != 2'b00) begin
      hit = 1'b1; d = op[8]; v = d ? a1 : a0;
      if (op[11:10] == 2'b11) s = int'($signed(d ? a0[31:16] : a1[31:16]));
      else                    s = int'($signed(op[9] ? x1 : x0));
      if (s >= 0) r = m_shl(v, s);
      else if ((op[11:10] == 2'b11) ? op[9] : op[11]) r = m_sar(v, -s);
      else r = m_shr(v, -s);
    end else if (op[15:8] == 8'hF0 || op[15:8] == 8'hF1) begin
      hit = 1'b1; d = op[8]; r = m_shl(d ? a1 : a0, 16);
    end else if (op[15:8] == 8'hF4 || op[15:8] == 8'hF5) begin
      hit = 1'b1; d = op[8]; r = m_shr(d ? a1 : a0, 16);
    end else if (op[15:12] == 4'b1001 && op[10:8] == 3'b001) begin
      hit = 1'b1; d = op[11]; r = m_sar(d ? a1 : a0, 16);
    end
  endfunction

  task automatic send(input logic [15:0] op, input logic [39:0] a0, a1,
                      input logic [15:0] x0, x1, input bit vld, input string tag);
    item_t it;
    bit h, d;
    logic [39:0] r;
    @(posedge clk); #2;
    valid_i = vld; instr_i = op; acc0_i = a0; acc1_i = a1; axh0_i = x0; axh1_i = x1;
    model(op, a0, a1, x0, x1, h, d, r);
    it.v = vld && h; it.d = d; it.r = r; it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (valid_o !== it.v) begin
        errors++;
        $display("FAIL %s valid actual %b expected %b", it.tag, valid_o, it.v);
      end else if (it.v && (dst_o !== it.d || res_o !== it.r || zero_o !== (it.r == 0) ||
                            sign_o !== it.r[39] || ovf_o !== 1'b0)) begin
        errors++;
        $display("FAIL %s actual d=%b r=%h z=%b s=%b o=%b expected d=%b r=%h z=%b s=%b o=0",
                 it.tag, dst_o, res_o, zero_o, sign_o, ovf_o,
                 it.d, it.r, (it.r == 0), it.r[39]);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R12 reset state
    if ({valid_o, dst_o, res_o, zero_o, sign_o, ovf_o} !== '0) begin
      errors++;
      $display("FAIL R12 reset outputs actual %h expected 0",
               {valid_o, dst_o, res_o, zero_o, sign_o, ovf_o});
    end
    rst_n = 1'b1;

    // R1 / R3 immediate left
    send(16'h1400, 40'h12_3456_789A, 40'h0, 16'h0, 16'h0, 1, "R3");
    send(16'h1504, 40'h0, 40'hF1_2345_6789, 16'h0, 16'h0, 1, "R1");
    send(16'h1588, 40'h0, 40'h00_00FF_0001, 16'h0, 16'h0, 1, "R1");
    // R2 / R4 / R5 immediate right
    send(16'h147C, 40'h80_0000_0010, 40'h0, 16'h0, 16'h0, 1, "R2");
    send(16'h1440, 40'hFF_FFFF_FFFF, 40'h0, 16'h0, 16'h0, 1, "R2");
    send(16'h14FC, 40'h80_0000_0010, 40'h0, 16'h0, 16'h0, 1, "R4");
    send(16'h15C0, 40'h0, 40'h90_0000_0000, 16'h0, 16'h0, 1, "R5");
    // R6 fixed operands
    send(16'h02CA, 40'h80_0000_00F0, 40'h00_0004_0000, 16'h0, 16'h0, 1, "R6");
    send(16'h02CB, 40'h00_0000_0001, 40'h00_FFF8_0000, 16'h0, 16'h0, 1, "R6");
    send(16'h02CA, 40'hAB_CDEF_0123, 40'h00_0000_FFFF, 16'h0, 16'h0, 1, "R6");
    send(16'h02CB, 40'h80_0000_0000, 40'h00_0064_0000, 16'h0, 16'h0, 1, "R5");
    send(16'h02CA, 40'h80_0000_0000, 40'h00_0064_0000, 16'h0, 16'h0, 1, "R5");
    // R7 auxiliary-word amounts
    send(16'h3680, 40'h10_0000_0001, 40'h0, 16'h0, 16'h0003, 1, "R7");
    send(16'h3980, 40'h0, 40'h80_0000_0100, 16'hFFFC, 16'h0, 1, "R7");
    send(16'h3480, 40'h80_0000_0100, 40'h0, 16'hFFFC, 16'h0, 1, "R7");
    // R8 other-accumulator amounts
    send(16'h3C80, 40'h80_1234_5678, 40'h00_FFF0_0000, 16'h0, 16'h0, 1, "R8");
    send(16'h3F80, 40'h00_0002_0000, 40'h20_0000_0003, 16'h0, 16'h0, 1, "R8");
    send(16'h3E80, 40'h80_0000_0000, 40'h00_FFFC_0000, 16'h0, 16'h0, 1, "R8");
    // R9 fixed sixteen
    send(16'h F100, 40'h0, 40'h12_3456_789A, 16'h0, 16'h0, 1, "R9");
    send(16'hF400, 40'h92_3456_789A, 40'h0, 16'h0, 16'h0, 1, "R9");
    send(16'h9900, 40'h0, 40'h92_3456_789A, 16'h0, 16'h0, 1, "R9");
    // R10 zero flag from a shifted-out value
    send(16'h1428, 40'h00_0000_0001, 40'h0, 16'h0, 16'h0, 1, "R10");
    // R11 no result for non-shift word or idle cycle
    send(16'h3080, 40'h1, 40'h1, 16'h1, 16'h1, 1, "R11");
    send(16'h1404, 40'h1, 40'h1, 16'h0, 16'h0, 0, "R11");
    send(16'h0000, 40'h1, 40'h1, 16'h0, 16'h0, 1, "R11");

    @(posedge clk); #2 valid_i = 1'b0;
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule